// File: doc/BRIEF.md
# Row Activate Spacing Gate

This block stands between a DRAM controller's command scheduler and its command bus and decides when a requested row activation may go out. The scheduler presents a bank number with a valid flag. The gate raises ready in the cycle in which every spacing rule for that bank is met, and a grant strobe marks the cycle in which the activation is accepted. The scheduler holds the request steady until it sees the grant.

Three kinds of rule are enforced. The first is a minimum distance between any two activations. The second limits a rolling window to four activations when the device has eight banks. The third is per-bank: a bank needs a full row cycle since its own last activation and a full precharge interval since it was closed. All limits are given in clock cycles. A page-size select picks between two sets of values for the activation distance and the window length. A per-bank precharge input closes banks and starts their precharge timers.

Top module: `act_spacing_gate`

## Requirements
- R1: Out of reset every timer reads as expired, so req_ready is 1 and a first request to any bank is granted in the cycle it is presented.
- R2: After a grant in cycle t, no grant occurs before cycle t+D, where D is the selected activation distance. A request already waiting for that cycle is granted in exactly that cycle.
- R3: A distance value below 2 is raised to 2, so two grants are never less than two cycles apart.
- R4: page_big=0 selects cfg_rrd_small and cfg_faw_small. page_big=1 selects cfg_rrd_large and cfg_faw_large.
- R5: With eight_bank_mode=1, a grant is held until at least W cycles have passed since the fourth most recent grant, where W is the selected window length.
- R6: With eight_bank_mode=0 the window limit does not apply. Back-to-back requests are then spaced by the distance D alone.
- R7: A bank is granted only when at least cfg_rc cycles have passed since its own previous grant.
- R8: A bank is granted only when at least cfg_rp cycles have passed since the cycle in which its bit of pre_vec was high.
- R9: A bank that has been activated and not yet precharged is never granted, and req_ready stays 0 for it.
- R10: grant is 1 exactly when req_valid and req_ready are both 1, and grant_bank then equals req_bank. With req_valid at 0 no grant occurs.
- R11: A precharge to one bank does not make any other bank grantable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Activation request present |
| req_bank | input | 3 | Bank index of the request |
| req_ready | output | 1 | All spacing rules met for req_bank this cycle |
| grant | output | 1 | Activation accepted this cycle |
| grant_bank | output | 3 | Bank of the accepted activation |
| pre_vec | input | 8 | One bit per bank, high for one cycle when that bank is precharged |
| page_big | input | 1 | Selects the large-page timing set |
| eight_bank_mode | input | 1 | Enables the four-activation window |
| cfg_rrd_small | input | 6 | Activation distance in cycles, small page |
| cfg_rrd_large | input | 6 | Activation distance in cycles, large page |
| cfg_faw_small | input | 6 | Window length in cycles, small page |
| cfg_faw_large | input | 6 | Window length in cycles, large page |
| cfg_rc | input | 6 | Same-bank row cycle in cycles |
| cfg_rp | input | 6 | Precharge interval in cycles |

## Verification
The checker assumes that a precharge pulse never targets the bank being granted in the same cycle. It also assumes that the configuration inputs change only while nothing is requested, because its thresholds are read from the live configuration. The bench changes settings only between scenarios, with req_valid low and after a reset. It raises a pre_vec bit only in a cycle without a grant to that bank. Requests are held until granted, so a grant cycle that has drifted shows up as a measured distance from an earlier grant.

// File: rtl/act_gate_pkg.sv
package act_gate_pkg;
    // number of activations tracked by the rolling window
    localparam int WIN_ACTS  = 4;
    // lowest legal activation distance in cycles
    localparam int RRD_FLOOR = 2;
endpackage

// File: rtl/act_bank_timer.sv
module act_bank_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_hit,
    input  logic             pre_hit,
    input  logic [CNT_W-1:0] cfg_rc,
    input  logic [CNT_W-1:0] cfg_rp,
    output logic             bank_ok
);
    localparam logic [CNT_W-1:0] AGE_MAX = '1;
    localparam logic [CNT_W-1:0] AGE_ONE = CNT_W'(1);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] act_age;
        logic [CNT_W-1:0] pre_age;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.act_age != AGE_MAX) st_d.act_age = st_q.act_age + AGE_ONE;
        if (st_q.pre_age != AGE_MAX) st_d.pre_age = st_q.pre_age + AGE_ONE;
        if (act_hit) begin
            st_d.open    = 1'b1;
            st_d.act_age = AGE_ONE;
        end else if (pre_hit) begin
            st_d.open    = 1'b0;
            st_d.pre_age = AGE_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{open: 1'b0, act_age: AGE_MAX, pre_age: AGE_MAX};
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_ok = !st_q.open && (st_q.act_age >= cfg_rc) && (st_q.pre_age >= cfg_rp);
endmodule

// File: rtl/act_window.sv
module act_window #(
    parameter int CNT_W = 6,
    parameter int DEPTH = act_gate_pkg::WIN_ACTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [CNT_W-1:0] rrd_need,
    input  logic [CNT_W-1:0] faw_need,
    input  logic             faw_en,
    output logic             spacing_ok
);
    localparam logic [CNT_W-1:0] AGE_MAX = '1;
    localparam logic [CNT_W-1:0] AGE_ONE = CNT_W'(1);

    typedef struct packed {
        logic [DEPTH-1:0][CNT_W-1:0] age;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [DEPTH-1:0][CNT_W-1:0] aged;

    // every slot ages by one cycle and saturates
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        assign aged[i] = (st_q.age[i] == AGE_MAX) ? AGE_MAX : st_q.age[i] + AGE_ONE;
    end

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.age[0] = AGE_ONE;
            for (int i = 1; i < DEPTH; i++) st_d.age[i] = aged[i-1];
        end else begin
            st_d.age = aged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.age <= {DEPTH{AGE_MAX}};
        end else begin
            st_q <= st_d;
        end
    end

    assign spacing_ok = (st_q.age[0] >= rrd_need) &&
                        (!faw_en || (st_q.age[DEPTH-1] >= faw_need));
endmodule

// File: rtl/act_spacing_gate.sv
module act_spacing_gate #(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 6,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    output logic                 req_ready,
    output logic                 grant,
    output logic [BANK_W-1:0]    grant_bank,
    input  logic [NUM_BANKS-1:0] pre_vec,
    input  logic                 page_big,
    input  logic                 eight_bank_mode,
    input  logic [CNT_W-1:0]     cfg_rrd_small,
    input  logic [CNT_W-1:0]     cfg_rrd_large,
    input  logic [CNT_W-1:0]     cfg_faw_small,
    input  logic [CNT_W-1:0]     cfg_faw_large,
    input  logic [CNT_W-1:0]     cfg_rc,
    input  logic [CNT_W-1:0]     cfg_rp
);
    localparam logic [CNT_W-1:0] RRD_MIN = CNT_W'(act_gate_pkg::RRD_FLOOR);

    logic [CNT_W-1:0]     rrd_sel, rrd_need, faw_need;
    logic                 spacing_ok;
    logic [NUM_BANKS-1:0] bank_ok_vec;

    // page-size set selection and distance floor
    always_comb begin
        rrd_sel  = page_big ? cfg_rrd_large : cfg_rrd_small;
        faw_need = page_big ? cfg_faw_large : cfg_faw_small;
        rrd_need = (rrd_sel < RRD_MIN) ? RRD_MIN : rrd_sel;
    end

    act_window #(.CNT_W(CNT_W)) win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (grant),
        .rrd_need   (rrd_need),
        .faw_need   (faw_need),
        .faw_en     (eight_bank_mode),
        .spacing_ok (spacing_ok)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        act_bank_timer #(.CNT_W(CNT_W)) timer_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_hit (grant && (req_bank == BANK_W'(b))),
            .pre_hit (pre_vec[b]),
            .cfg_rc  (cfg_rc),
            .cfg_rp  (cfg_rp),
            .bank_ok (bank_ok_vec[b])
        );
    end

    assign req_ready  = spacing_ok && bank_ok_vec[req_bank];
    assign grant      = req_valid && req_ready;
    assign grant_bank = req_bank;
endmodule

// File: rtl/act_spacing_gate_chk.sv
module act_spacing_gate_chk #(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 6,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [BANK_W-1:0]    req_bank,
    input logic                 req_ready,
    input logic                 grant,
    input logic [BANK_W-1:0]    grant_bank,
    input logic [NUM_BANKS-1:0] pre_vec,
    input logic                 page_big,
    input logic                 eight_bank_mode,
    input logic [CNT_W-1:0]     cfg_rrd_small,
    input logic [CNT_W-1:0]     cfg_rrd_large,
    input logic [CNT_W-1:0]     cfg_faw_small,
    input logic [CNT_W-1:0]     cfg_faw_large,
    input logic [CNT_W-1:0]     cfg_rc,
    input logic [CNT_W-1:0]     cfg_rp
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] gap_q;
    logic [3:0][CNT_W-1:0] hist_q;
    logic [NUM_BANKS-1:0][CNT_W-1:0] bact_q, bpre_q;
    logic [NUM_BANKS-1:0] open_q;
    logic [CNT_W-1:0] d_sel, d_min, w_min;

    assign d_sel = page_big ? cfg_rrd_large : cfg_rrd_small;
    assign d_min = (d_sel > TWO) ? d_sel : TWO;
    assign w_min = page_big ? cfg_faw_large : cfg_faw_small;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= TOP;
            hist_q <= {4{TOP}};
            bact_q <= {NUM_BANKS{TOP}};
            bpre_q <= {NUM_BANKS{TOP}};
            open_q <= '0;
        end else begin
            gap_q <= grant ? ONE : ((gap_q == TOP) ? TOP : gap_q + ONE);
            for (int i = 0; i < 4; i++) begin
                if (grant) hist_q[i] <= (i == 0) ? ONE : ((hist_q[i-1] == TOP) ? TOP : hist_q[i-1] + ONE);
                else       hist_q[i] <= (hist_q[i] == TOP) ? TOP : hist_q[i] + ONE;
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                bact_q[b] <= (bact_q[b] == TOP) ? TOP : bact_q[b] + ONE;
                bpre_q[b] <= (bpre_q[b] == TOP) ? TOP : bpre_q[b] + ONE;
                if (grant && grant_bank == BANK_W'(b)) begin
                    bact_q[b] <= ONE;
                    open_q[b] <= 1'b1;
                end else if (pre_vec[b]) begin
                    bpre_q[b] <= ONE;
                    open_q[b] <= 1'b0;
                end
            end
        end
    end

    p_act_distance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> gap_q >= d_min);
    p_distance_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> gap_q >= TWO);
    p_four_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && eight_bank_mode) |-> hist_q[3] >= w_min);
    p_row_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> bact_q[grant_bank] >= cfg_rc);
    p_precharge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> bpre_q[grant_bank] >= cfg_rp);
    p_closed_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !open_q[grant_bank]);
endmodule

bind act_spacing_gate act_spacing_gate_chk #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/act_spacing_gate_tb_top.sv
module act_spacing_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_bank = '0;
    logic       req_ready, grant;
    logic [2:0] grant_bank;
    logic [7:0] pre_vec = '0;
    logic       page_big = 1'b0;
    logic       eight_bank_mode = 1'b1;
    logic [5:0] cfg_rrd_small = 6'd3, cfg_rrd_large = 6'd4;
    logic [5:0] cfg_faw_small = 6'd14, cfg_faw_large = 6'd20;
    logic [5:0] cfg_rc = 6'd10, cfg_rp = 6'd3;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    act_spacing_gate dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        pre_vec   = '0;
        rst_n     = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // request a bank and hold it until granted; returns grant cycle
    task automatic issue(input int b, output int gc);
        int waited = 0;
        req_valid = 1'b1;
        req_bank  = 3'(b);
        forever begin
            @(negedge clk);
            if (grant) break;
            waited++;
            if (waited > 200) begin
                chk(1'b0, "issue timeout", waited, 0);
                break;
            end
            @(posedge clk); #1;
        end
        gc = cyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic precharge(input int b, output int pc);
        pre_vec[b] = 1'b1;
        pc = cyc;
        @(posedge clk); #1;
        pre_vec = '0;
    endtask

    task automatic t_reset();
        int g;
        do_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(grant == 1'b0, "R10 no grant without valid", int'(grant), 0);
        @(posedge clk); #1;
        req_valid = 1'b1; req_bank = 3'd6;
        @(negedge clk);
        chk(grant == 1'b1, "R1 first request granted at once", int'(grant), 1);
        chk(grant_bank == 3'd6, "R10 grant_bank", int'(grant_bank), 6);
        @(posedge clk); #1 req_valid = 1'b0;
    endtask

    task automatic t_rrd();
        int g0, g1;
        do_reset();
        issue(0, g0); issue(1, g1);
        chk(g1 - g0 == 3, "R2 distance small page", g1 - g0, 3);
        cfg_rrd_small = 6'd1;
        do_reset();
        issue(0, g0); issue(1, g1);
        chk(g1 - g0 == 2, "R3 floor with value 1", g1 - g0, 2);
        cfg_rrd_small = 6'd0;
        do_reset();
        issue(0, g0); issue(1, g1);
        chk(g1 - g0 == 2, "R3 floor with value 0", g1 - g0, 2);
        cfg_rrd_small = 6'd3;
    endtask

    task automatic t_window(input bit big, input bit eight);
        int g[6];
        int d, w, exp5, exp6;
        page_big = big; eight_bank_mode = eight;
        do_reset();
        for (int i = 0; i < 6; i++) issue(i, g[i]);
        d = big ? 4 : 3;
        w = big ? 20 : 14;
        exp5 = eight ? ((g[3] + d > g[0] + w) ? g[3] + d : g[0] + w) : g[3] + d;
        chk(g[1] - g[0] == d, "R4 distance follows page select", g[1] - g[0], d);
        if (!eight) begin
            chk(g[4] == exp5, "R6 no window limit in four-bank mode", g[4] - g[0], exp5 - g[0]);
        end else if (big) begin
            chk(g[4] == exp5, "R4 large window selected", g[4] - g[0], exp5 - g[0]);
        end else begin
            chk(g[4] == exp5, "R5 fifth activation held by window", g[4] - g[0], exp5 - g[0]);
            exp6 = (g[4] + d > g[1] + w) ? g[4] + d : g[1] + w;
            chk(g[5] == exp6, "R5 sixth activation", g[5] - g[0], exp6 - g[0]);
        end
        page_big = 1'b0; eight_bank_mode = 1'b1;
    endtask

    task automatic t_same_bank(input int rp);
        int g0, p, g1, e;
        cfg_rp = 6'(rp);
        do_reset();
        issue(0, g0);
        precharge(0, p);
        issue(0, g1);
        e = (g0 + 10 > p + rp) ? g0 + 10 : p + rp;
        if (rp < 10) chk(g1 == e, "R7 row cycle limits reuse", g1 - g0, e - g0);
        else         chk(g1 == e, "R8 precharge interval limits reuse", g1 - g0, e - g0);
        cfg_rp = 6'd3;
    endtask

    task automatic t_open_bank();
        int g0, p, g1, seen, rdy;
        do_reset();
        issue(2, g0);
        req_valid = 1'b1; req_bank = 3'd2;
        seen = 0; rdy = 0;
        for (int i = 0; i < 30; i++) begin
            if (i == 15) pre_vec[5] = 1'b1;
            @(negedge clk);
            if (grant) seen++;
            if (req_ready) rdy++;
            @(posedge clk); #1;
            pre_vec = '0;
        end
        chk(seen == 0, "R9 open bank never granted", seen, 0);
        chk(rdy == 0, "R11 other-bank precharge leaves bank blocked", rdy, 0);
        req_valid = 1'b0;
        precharge(2, p);
        issue(2, g1);
        chk(g1 == p + 3, "R8 granted after precharge interval", g1 - p, 3);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rrd();
        t_window(1'b0, 1'b1);
        t_window(1'b1, 1'b1);
        t_window(1'b0, 1'b0);
        t_same_bank(3);
        t_same_bank(20);
        t_open_bank();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule